// File: doc/BRIEF.md
# Loadable Interval Timer

A single timer channel behind a small register-mapped write/read port. Software places a count value, up to 64 bits wide, into two 32-bit load words, then sets the enable bit in the control register. On that enable edge the counter takes the load value and steps down by one on every clock. When it has reached zero, the next step raises a sticky status flag.

In auto-reload mode the counter then refills itself from the load words and keeps counting. A load of N therefore gives a periodic event every N+1 clocks. In single-count mode the counter parks at zero once it has fired, and stays there until software clears the enable bit and sets it again.

The interrupt line is the status flag gated by an unmask bit in the control register. The flag is cleared by writing a one to the status register. The clock-domain crossing and the interrupt controller sit outside the block.

Top module: `lt_timer`

## Requirements
- R1: After reset the control register, the status flag, both load words and `irq_o` are all zero.
- R2: The load value's low word is written and read at address 0x00 and its high word at 0x04; together they form bits 63:0 of the count.
- R3: A control write that takes bit 0 (enable) from 0 to 1 at clock edge W loads the counter, and the first status set happens at edge W+N+1 for a load value N.
- R4: With control bit 1 at 0 (auto-reload), the counter refills from the load words on each expiry, giving one status set every N+1 clocks.
- R5: With control bit 1 at 1 (single count), the status is set once per enable edge. The counter then holds at zero with no further sets until enable is cleared and set again.
- R6: Writing address 0x18 with bit 0 at 1 clears the status flag, and writing it with bit 0 at 0 has no effect. An expiry at the same edge as a clear leaves the flag set.
- R7: `irq_o` is high exactly when the status flag and control bit 2 (unmask) are both high. The flag keeps its value while masked.
- R8: While enable is 0 the counter holds and no status set occurs.
- R9: A load write made while the timer runs changes only the period that starts at the next reload.
- R10: The control register reads back on bits 2:0 at 0x10, with the upper bits reading zero whatever was written. The status flag reads on bit 0 at 0x18, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A wrong count or a missed reload shows up at `irq_o` as an event on the wrong cycle. The bench therefore predicts the exact edge of every rising interrupt and compares it to the cycle in which the edge appears. An error is visible within one period of the load value. A status flag that fails to stick, or that clears wrongly, can be read at 0x18 one cycle after the stimulus, even while the interrupt is masked. A counter that runs while disabled produces an unexpected rising edge within N+1 clocks of the next unmask, and the monitor reports any rising edge it was not told to expect.

// File: rtl/lt_timer_pkg.sv
package lt_timer_pkg;

   localparam logic [7:0] OFF_LOAD_BASE = 8'h00;
   localparam logic [7:0] OFF_CTRL      = 8'h10;
   localparam logic [7:0] OFF_STAT      = 8'h18;
   localparam int         WORD_STRIDE   = 4;
   localparam int         MAX_WORDS     = 4;

   typedef struct packed {
      logic irq_unmask;
      logic one_shot;
      logic enable;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/lt_timer_regs.sv
module lt_timer_regs
   import lt_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              status,
   output logic [CNT_W-1:0]  load_val,
   output ctrl_t             ctrl,
   output logic              en_rise,
   output logic              stat_clr,
   output logic [DATA_W-1:0] rdata
);

   localparam int N_WORDS = CNT_W / DATA_W;

   logic [DATA_W-1:0] word_q [N_WORDS];
   ctrl_t             ctrl_q;
   logic              ctrl_hit;
   logic              stat_hit;

   assign ctrl_hit = wr_en && (addr == ADDR_W'(OFF_CTRL));
   assign stat_hit = wr_en && (addr == ADDR_W'(OFF_STAT));

   for (genvar g = 0; g < N_WORDS; g++) begin : g_load
      localparam logic [ADDR_W-1:0] WORD_ADDR =
         ADDR_W'(int'(OFF_LOAD_BASE) + g * WORD_STRIDE);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q[g] <= '0;
         end else if (wr_en && (addr == WORD_ADDR)) begin
            word_q[g] <= wdata;
         end
      end

      assign load_val[g*DATA_W +: DATA_W] = word_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_hit) begin
         ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   assign ctrl     = ctrl_q;
   assign en_rise  = ctrl_hit && wdata[0] && !ctrl_q.enable;
   assign stat_clr = stat_hit && wdata[0];

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_WORDS; i++) begin
         if (addr == ADDR_W'(int'(OFF_LOAD_BASE) + i * WORD_STRIDE)) begin
            rdata = word_q[i];
         end
      end
      if (addr == ADDR_W'(OFF_CTRL)) begin
         rdata[CTRL_W-1:0] = ctrl_q;
      end
      if (addr == ADDR_W'(OFF_STAT)) begin
         rdata[0] = status;
      end
   end

endmodule

// File: rtl/lt_timer_count.sv
module lt_timer_count #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             one_shot,
   input  logic             en_rise,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             at_zero;
   logic             active;

   assign at_zero = (cnt_q == '0);
   assign active  = enable && !done_q;
   assign expire  = active && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (en_rise) begin
         cnt_q  <= load_val;
         done_q <= 1'b0;
      end else if (active) begin
         if (at_zero) begin
            cnt_q  <= one_shot ? '0 : load_val;
            done_q <= one_shot;
         end else begin
            cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt  = cnt_q;
   assign done = done_q;

endmodule

// File: rtl/lt_timer_irq.sv
module lt_timer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic stat_clr,
   input  logic unmask,
   output logic status,
   output logic irq
);

   logic status_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (expire) begin
         status_q <= 1'b1;
      end else if (stat_clr) begin
         status_q <= 1'b0;
      end
   end

   assign status = status_q;
   assign irq    = status_q && unmask;

endmodule

// File: rtl/lt_timer.sv
module lt_timer
   import lt_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   if ((CNT_W % DATA_W) != 0) begin : g_bad_split
      $error("CNT_W must be a whole number of DATA_W words");
   end
   if ((CNT_W / DATA_W) > MAX_WORDS) begin : g_bad_words
      $error("load value needs more words than the map has room for");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("DATA_W too narrow for the control field");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt;
   logic             en_rise;
   logic             stat_clr;
   logic             expire;
   logic             done;
   logic             status;
   logic             ctl_en;
   logic             ctl_one;
   logic             ctl_unm;

   assign ctl_en  = ctrl.enable;
   assign ctl_one = ctrl.one_shot;
   assign ctl_unm = ctrl.irq_unmask;

   lt_timer_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .status   (status),
      .load_val (load_val),
      .ctrl     (ctrl),
      .en_rise  (en_rise),
      .stat_clr (stat_clr),
      .rdata    (bus_rdata)
   );

   lt_timer_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctl_en),
      .one_shot (ctl_one),
      .en_rise  (en_rise),
      .load_val (load_val),
      .cnt      (cnt),
      .expire   (expire),
      .done     (done)
   );

   lt_timer_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .stat_clr (stat_clr),
      .unmask   (ctl_unm),
      .status   (status),
      .irq      (irq_o)
   );

endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk
   import lt_timer_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdata_b0,
   input logic              irq_o,
   input logic              enable,
   input logic              one_shot,
   input logic              unmask,
   input logic              status,
   input logic              expire,
   input logic              done,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  load_val
);

   logic ctrl_wr;
   logic clr_wr;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_STAT)) && wdata_b0;

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !unmask |-> !irq_o); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      status && !clr_wr |=> status); // R7

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr && !expire |=> !status); // R6

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> status); // R6

   AST_OFF_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !expire); // R8

   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !ctrl_wr |=> $stable(cnt)); // R8

   AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !one_shot |=> cnt == $past(load_val)); // R4

   AST_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      done && enable && !ctrl_wr |=> (cnt == '0) && done); // R5

endmodule

bind lt_timer lt_timer_chk #(
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wdata_b0 (bus_wdata[0]),
   .irq_o    (irq_o),
   .enable   (ctl_en),
   .one_shot (ctl_one),
   .unmask   (ctl_unm),
   .status   (status),
   .expire   (expire),
   .done     (done),
   .cnt      (cnt),
   .load_val (load_val)
);

// File: tb/tb_lt_timer.sv
module tb_lt_timer;

   localparam logic [7:0] A_LO   = 8'h00;
   localparam logic [7:0] A_HI   = 8'h04;
   localparam logic [7:0] A_CTRL = 8'h10;
   localparam logic [7:0] A_STAT = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int exp_q[$];
   logic irq_prev = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lt_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_irq();
      while (!irq_o) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // monitor: every rising interrupt must match the next expected cycle
   always @(negedge clk) begin
      int e;
      if (rst_n && irq_o && !irq_prev) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4: unexpected interrupt at cycle %0d, expected none", cyc);
         end else begin
            e = exp_q.pop_front();
            check("R3 R4 interrupt cycle", 64'(cyc), 64'(e));
         end
      end
      irq_prev = irq_o;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 64'(irq_o), 64'h0);
      rd(A_CTRL, d); check("R1 ctrl", 64'(d), 64'h0);
      rd(A_STAT, d); check("R1 status", 64'(d), 64'h0);
      rd(A_LO, d);   check("R1 load lo", 64'(d), 64'h0);
      rd(A_HI, d);   check("R1 load hi", 64'(d), 64'h0);
      @(negedge clk);

      // R2 load words, R10 read map
      wr(A_LO, 32'hDEADBEEF);
      wr(A_HI, 32'h12345678);
      rd(A_LO, d); check("R2 lo word", 64'(d), 64'hDEADBEEF);
      rd(A_HI, d); check("R2 hi word", 64'(d), 64'h12345678);
      rd(8'h08, d); check("R10 unmapped", 64'(d), 64'h0);
      @(negedge clk);
      wr(A_CTRL, 32'hFFFF_FFF8);
      rd(A_CTRL, d); check("R10 ctrl upper bits", 64'(d), 64'h0);
      @(negedge clk);

      // R3 R4 R9 auto-reload, load 9 -> every 10 clocks, then 4 -> 5
      wr(A_LO, 32'd9);
      wr(A_HI, 32'd0);
      w = cyc + 1;
      exp_q.push_back(w + 10);
      exp_q.push_back(w + 20);
      exp_q.push_back(w + 25);
      wr(A_CTRL, 32'h5);
      wait_irq();
      wr(A_STAT, 32'h1);
      wr(A_LO, 32'd4);       // R9 applies at next reload
      wait_irq();
      wr(A_STAT, 32'h1);
      wait_irq();
      wr(A_STAT, 32'h1);
      wr(A_CTRL, 32'h0);
      check("R4 R9 all periodic events seen", 64'(exp_q.size()), 64'h0);

      // R8 disabled timer stays quiet
      repeat (30) @(negedge clk);
      check("R8 irq while off", 64'(irq_o), 64'h0);
      rd(A_STAT, d); check("R8 status while off", 64'(d), 64'h0);
      @(negedge clk);

      // R5 R7 single count, masked
      wr(A_CTRL, 32'h3);
      repeat (12) @(negedge clk);
      check("R7 masked irq", 64'(irq_o), 64'h0);
      rd(A_STAT, d); check("R7 status kept while masked", 64'(d), 64'h1);
      @(negedge clk);
      exp_q.push_back(cyc + 1);
      wr(A_CTRL, 32'h7);
      check("R7 unmask raises irq", 64'(irq_o), 64'h1);
      wr(A_STAT, 32'h0);
      rd(A_STAT, d); check("R6 write 0 no effect", 64'(d), 64'h1);
      @(negedge clk);
      wr(A_STAT, 32'h1);
      check("R6 clear irq", 64'(irq_o), 64'h0);
      rd(A_STAT, d); check("R6 clear status", 64'(d), 64'h0);
      @(negedge clk);
      repeat (20) @(negedge clk);
      check("R5 no second expiry", 64'(irq_o), 64'h0);
      rd(A_STAT, d); check("R5 status stays clear", 64'(d), 64'h0);
      @(negedge clk);
      wr(A_CTRL, 32'h0);
      exp_q.push_back(cyc + 1 + 5);
      wr(A_CTRL, 32'h7);
      wait_irq();
      @(negedge clk);
      check("R5 re-enable fires again", 64'(exp_q.size()), 64'h0);
      wr(A_STAT, 32'h1);
      wr(A_CTRL, 32'h0);

      // R6 expiry and clear on the same edge: set wins
      wr(A_CTRL, 32'h1);
      repeat (4) @(negedge clk);
      wr(A_STAT, 32'h1);
      rd(A_STAT, d); check("R6 set beats clear", 64'(d), 64'h1);
      @(negedge clk);
      wr(A_CTRL, 32'h0);
      wr(A_STAT, 32'h1);
      rd(A_STAT, d); check("R6 final clear", 64'(d), 64'h0);
      @(negedge clk);

      repeat (5) @(negedge clk);
      check("R4 no stray expectations", 64'(exp_q.size()), 64'h0);
      summary();
      $finish;
   end

endmodule